// File: doc/BRIEF.md
# Parallel Bus Register Write Engine

This block sits on the host side of an 8080-style parallel link to a display controller and turns a stream of byte requests into bus write cycles. Each request arrives over a valid/ready handshake and carries one byte plus a flag. The flag says whether the byte selects a controller register (a command) or is a parameter or pixel byte for the register already selected.

For every accepted request the engine lowers chip select and sets the register-select line and data bus. It then pulses the active-low write strobe and holds everything for a short while before releasing chip select. Every phase length is a parameter counted in system clocks, so a chosen clock rate can meet the target's nanosecond minimums. The strobe's high time between two pulses is tracked. If back-to-back requests would make it too short, the setup phase of the next write is stretched. Only writes are produced; the data lines are always outputs.

Top module: `pbus_wr_engine`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `bus_cs_n` and `bus_wr_n` are 1 and `req_ready` is 1.
- R2: `bus_rs` is 0 for a request with `req_is_param` = 0 (command) and 1 for a request with `req_is_param` = 1 (parameter/data).
- R3: During an access the request byte is driven on `bus_d[8:1]` (bit 1 is the byte's LSB) and `bus_d[0]` is 0.
- R4: The strobe falls only inside a select window. `bus_cs_n` is low, with `bus_rs` and `bus_d` valid, for at least SETUP_CYC cycles before `bus_wr_n` falls.
- R5: `bus_wr_n` stays low for exactly LOW_CYC cycles per write.
- R6: After `bus_wr_n` rises, `bus_cs_n` stays low with `bus_rs` and `bus_d` unchanged for exactly HOLD_CYC cycles, then goes high.
- R7: Between two falling edges of `bus_wr_n` the strobe is high for at least HIGH_CYC cycles. When HIGH_CYC exceeds HOLD_CYC + SETUP_CYC + 1, back-to-back writes have exactly HIGH_CYC high cycles. The first write after reset or a long idle gets no extra setup.
- R8: `req_ready` is 1 exactly when `bus_cs_n` is 1. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the hold phase of that write ends.
- R9: While `bus_cs_n` is low, `bus_rs` and `bus_d` do not change, whatever happens on `req_data` and `req_is_param`.
- R10: `bus_cs_n` returns high after every write, so each write has its own select window.
- R11: Each accepted request produces exactly one strobe pulse, in acceptance order. With `req_valid` low, no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_data | input | BYTE_W | Byte to write |
| req_is_param | input | 1 | 1: parameter/data byte, 0: register index |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rs | output | 1 | Register select: 0 command, 1 parameter |
| bus_d | output | BYTE_W+1 | Data field; byte on the upper BYTE_W lines, LSB line 0 |

## Verification
On every cycle, the bound checker holds four rules. The strobe only goes low inside a select window, and ready never overlaps a select. The bus is frozen for the whole window with a zero LSB line. Each strobe pulse is exactly LOW_CYC long. Three things can only be shown through the bench's scenarios. One is that each byte and its flag come out in order, once per accepted request. The others are the exact hold length and the stretching of setup that gives back-to-back writes their minimum high time, which the bench measures against an isolated write that gets no stretch.

// File: rtl/pbus_wr_pkg.sv
package pbus_wr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

endpackage

// File: rtl/pbus_cycle_counter.sv
// Saturating count of cycles spent in the current phase; restarts on clear.
module pbus_cycle_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    output logic [W-1:0] count
);

    logic [W-1:0] count_d;
    logic [W-1:0] count_q;

    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (count_q != {W{1'b1}}) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/pbus_high_tracker.sv
// Counts strobe-high cycles since the last low phase; flags when the
// current cycle completes the required minimum high time.
module pbus_high_tracker #(
    parameter int HIGH_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_low,
    output logic spaced
);

    localparam int HW = $clog2(HIGH_CYC + 1);

    logic [HW-1:0] high_d;
    logic [HW-1:0] high_q;

    always_comb begin
        high_d = high_q;
        if (strobe_low) begin
            high_d = '0;
        end else if (high_q != HW'(HIGH_CYC)) begin
            high_d = high_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            high_q <= HW'(HIGH_CYC);
        end else begin
            high_q <= high_d;
        end
    end

    assign spaced = (high_q >= HW'(HIGH_CYC - 1));

endmodule

// File: rtl/pbus_wr_engine.sv
module pbus_wr_engine #(
    parameter int SETUP_CYC = 1,
    parameter int LOW_CYC   = 2,
    parameter int HIGH_CYC  = 2,
    parameter int HOLD_CYC  = 1,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BYTE_W-1:0] req_data,
    input  logic              req_is_param,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rs,
    output logic [BYTE_W:0]   bus_d
);

    import pbus_wr_pkg::*;

    localparam int MAX_A = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
    localparam int MAX_L = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CW    = $clog2(MAX_L + 1);

    typedef struct packed {
        phase_e            ph;
        logic              rs;
        logic [BYTE_W-1:0] byte_v;
    } eng_s;

    eng_s          st_d;
    eng_s          st_q;
    logic [CW-1:0] cnt_q;
    logic          spaced;
    logic          phase_change;

    pbus_cycle_counter #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (phase_change),
        .count (cnt_q)
    );

    pbus_high_tracker #(.HIGH_CYC(HIGH_CYC)) u_high (
        .clk        (clk),
        .rst        (rst),
        .strobe_low (st_q.ph == PH_LOW),
        .spaced     (spaced)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph     = PH_SETUP;
                    st_d.rs     = req_is_param;
                    st_d.byte_v = req_data;
                end
            end
            PH_SETUP: begin
                if ((cnt_q >= CW'(SETUP_CYC - 1)) && spaced) begin
                    st_d.ph = PH_LOW;
                end
            end
            PH_LOW: begin
                if (cnt_q >= CW'(LOW_CYC - 1)) begin
                    st_d.ph = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (cnt_q >= CW'(HOLD_CYC - 1)) begin
                    st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    assign phase_change = (st_d.ph != st_q.ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph     <= PH_IDLE;
            st_q.rs     <= 1'b0;
            st_q.byte_v <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.ph == PH_IDLE);
    assign bus_cs_n  = (st_q.ph == PH_IDLE);
    assign bus_wr_n  = (st_q.ph != PH_LOW);
    assign bus_rs    = st_q.rs;
    assign bus_d     = {st_q.byte_v, 1'b0};

endmodule

// File: rtl/pbus_wr_engine_chk.sv
module pbus_wr_engine_chk #(
    parameter int LOW_CYC = 2,
    parameter int BYTE_W  = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic            bus_cs_n,
    input logic            bus_wr_n,
    input logic            bus_rs,
    input logic [BYTE_W:0] bus_d
);

    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
        end else if (!bus_wr_n) begin
            if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;
        end else begin
            low_run <= '0;
        end
    end

    AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> !bus_cs_n); // R4

    AST_FALL_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_wr_n) |-> !$past(bus_cs_n)); // R4

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> bus_cs_n); // R8

    AST_BUS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !$past(bus_cs_n)) |-> ($stable(bus_rs) && $stable(bus_d))); // R9

    AST_LSB_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> (bus_d[0] == 1'b0)); // R3

    AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> !bus_cs_n); // R6

    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> (low_run == 16'(LOW_CYC))); // R5

endmodule

bind pbus_wr_engine pbus_wr_engine_chk #(
    .LOW_CYC (LOW_CYC),
    .BYTE_W  (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .bus_cs_n  (bus_cs_n),
    .bus_wr_n  (bus_wr_n),
    .bus_rs    (bus_rs),
    .bus_d     (bus_d)
);

// File: tb/pbus_wr_engine_tb.sv
module pbus_wr_engine_tb;

    localparam int SETUP = 1;
    localparam int LOW   = 2;
    localparam int HIGH  = 4;
    localparam int HOLD  = 1;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_ready;
    logic [7:0] req_data;
    logic       req_is_param;
    logic       bus_cs_n;
    logic       bus_wr_n;
    logic       bus_rs;
    logic [8:0] bus_d;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [8:0] exp_q[$];
    int accepted = 0;
    int writes   = 0;
    int windows  = 0;

    always #5 clk = ~clk;

    pbus_wr_engine #(
        .SETUP_CYC (SETUP),
        .LOW_CYC   (LOW),
        .HIGH_CYC  (HIGH),
        .HOLD_CYC  (HOLD),
        .BYTE_W    (8)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_data     (req_data),
        .req_is_param (req_is_param),
        .bus_cs_n     (bus_cs_n),
        .bus_wr_n     (bus_wr_n),
        .bus_rs       (bus_rs),
        .bus_d        (bus_d)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: called at a negedge, returns at a negedge.
    task automatic send(input logic is_param, input logic [7:0] data);
        req_valid    = 1'b1;
        req_data     = data;
        req_is_param = is_param;
        while (!req_ready) @(negedge clk);
        exp_q.push_back({is_param, data});
        accepted++;
        @(negedge clk);
        req_valid    = 1'b0;
        req_data     = ~data;
        req_is_param = ~is_param;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!bus_cs_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor / scoreboard
    logic prev_wr, prev_cs, prev_rs;
    logic [8:0] prev_d;
    int setup_cnt, low_cnt, hi_cnt, hold_cnt, last_hi, last_setup;
    bit in_hold, first_fall;

    always @(negedge clk) begin
        if (rst) begin
            prev_wr = 1'b1; prev_cs = 1'b1; prev_rs = 1'b0; prev_d = '0;
            setup_cnt = 0; low_cnt = 0; hi_cnt = 1000; hold_cnt = 0;
            last_hi = 0; last_setup = 0; in_hold = 0; first_fall = 1;
        end else begin
            logic [8:0] item;
            bit fall, rise;
            fall = prev_wr && !bus_wr_n;
            rise = !prev_wr && bus_wr_n;
            chk(req_ready == bus_cs_n, "R8 ready equals idle select", req_ready, bus_cs_n);
            if (!bus_cs_n && !prev_cs) begin
                chk(bus_rs == prev_rs && bus_d == prev_d, "R9 bus frozen in window",
                    {bus_rs, bus_d}, {prev_rs, prev_d});
            end
            if (prev_cs && !bus_cs_n) begin
                windows++;
                setup_cnt = 0;
            end
            if (!bus_cs_n && bus_wr_n && !in_hold) setup_cnt++;
            if (fall) begin
                chk(setup_cnt >= SETUP, "R4 setup before strobe", setup_cnt, SETUP);
                if (!first_fall) chk(hi_cnt >= HIGH, "R7 strobe high time", hi_cnt, HIGH);
                last_hi    = hi_cnt;
                last_setup = setup_cnt;
                first_fall = 0;
                hi_cnt     = 0;
                low_cnt    = 1;
            end else if (!bus_wr_n) begin
                low_cnt++;
            end else if (hi_cnt < 1000) begin
                hi_cnt++;
            end
            if (rise) begin
                writes++;
                chk(low_cnt == LOW, "R5 strobe low width", low_cnt, LOW);
                chk(exp_q.size() > 0, "R11 strobe without request", exp_q.size(), 1);
                if (exp_q.size() > 0) begin
                    item = exp_q.pop_front();
                    chk(bus_rs == item[8], "R2 rs level", bus_rs, item[8]);
                    chk(bus_d[8:1] == item[7:0], "R3 byte on upper lines", bus_d[8:1], item[7:0]);
                end
                chk(bus_d[0] == 1'b0, "R3 lsb line zero", bus_d[0], 0);
                in_hold  = 1;
                hold_cnt = 1;
            end else if (in_hold && !bus_cs_n) begin
                hold_cnt++;
            end
            if (in_hold && bus_cs_n) begin
                chk(hold_cnt == HOLD, "R6 hold after strobe", hold_cnt, HOLD);
                in_hold = 0;
            end
            prev_wr = bus_wr_n;
            prev_cs = bus_cs_n;
            prev_rs = bus_rs;
            prev_d  = bus_d;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat [6];
        int w0;
        pat[0] = 8'hFF; pat[1] = 8'h00; pat[2] = 8'hA5;
        pat[3] = 8'h5A; pat[4] = 8'h80; pat[5] = 8'h01;
        rst = 1'b1; req_valid = 1'b0; req_data = '0; req_is_param = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_wr_n && req_ready, "R1 idle levels in reset",
            {bus_cs_n, bus_wr_n, req_ready}, 7);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_cs_n && bus_wr_n && req_ready, "R1 idle levels after reset",
            {bus_cs_n, bus_wr_n, req_ready}, 7);

        // Isolated command: no setup stretch
        send(1'b0, 8'h2A);
        wait_idle();
        chk(last_setup == SETUP, "R7 isolated write not stretched", last_setup, SETUP);

        // Back-to-back mixed commands and parameters
        for (int i = 0; i < 6; i++) send(i[0], pat[i]);
        wait_idle();
        chk(last_hi == HIGH, "R7 back-to-back high time exact", last_hi, HIGH);

        // Quiet period: no strobes, select stays high
        w0 = writes;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(bus_cs_n == 1'b1, "R10 select high when idle", bus_cs_n, 1);
        end
        chk(writes == w0, "R11 no strobe without valid", writes, w0);

        // Parameter burst after idle
        send(1'b1, 8'h3C);
        send(1'b1, 8'hC3);
        send(1'b0, 8'h7E);
        wait_idle();

        chk(exp_q.size() == 0, "R11 all requests written", exp_q.size(), 0);
        chk(writes == accepted, "R11 one strobe per request", writes, accepted);
        chk(windows == writes, "R10 one select window per write", windows, writes);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule